// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block decides when a DDR3 memory controller owes the device a refresh. A free-running interval timer, counted in controller clock cycles, marks each point at which one more refresh becomes due. A small counter holds the number of refreshes that are owed. The block offers them to the command arbiter through a valid/ready request channel. The arbiter may leave a request waiting while it serves traffic. Once eight refreshes are waiting, the block also raises an urgent level, because the device tolerates no more postponement than that. The time-based interval is turned into a cycle count at elaboration by rounding the quotient up. A hot input selects an interval half as long, for case temperatures above 85 °C.

Request channel rules: `req_valid_o` is high whenever at least one refresh is owed. Once raised, it stays high until a handshake removes the last owed refresh. A handshake happens at a rising clock edge where both `req_valid_o` and `req_ready_i` are high, and it retires exactly one owed refresh. Holding `req_ready_i` low is back-pressure: refreshes keep accumulating, up to a ceiling of nine. A further interval expiry at the ceiling, with no handshake in the same edge, sets a sticky overflow flag. Only reset clears that flag. Issuing the commands themselves, precharging banks and tracking refresh cycle time are left to the arbiter.

Top module: `rfsh_scheduler`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `owed_o` is 0 and `req_valid_o`, `req_urgent_o` and `overflow_o` are all 0.
- R2: With `hot_i` low, the normal interval is NORM = ceil(TREFI_PS / TCK_PS) cycles. The owed count rises by one at rising edge number NORM·k after reset release, for k = 1, 2, …, unless a handshake happens at that edge or the count is at its ceiling.
- R3: With `hot_i` high, the interval is HOT = ceil(TREFI_PS / (2·TCK_PS)) cycles. Expiries fall every HOT edges.
- R4: The elapsed-cycle count of the current interval is compared with the limit selected by `hot_i` at every cycle. When `hot_i` is raised after at least HOT−1 cycles of a normal interval have elapsed, that interval ends at the next edge and a new hot interval starts.
- R5: `req_valid_o` equals (`owed_o` ≠ 0). A handshake without a simultaneous interval expiry lowers `owed_o` by one.
- R6: While `req_ready_i` is low, `req_valid_o` does not fall and `owed_o` does not fall.
- R7: `req_urgent_o` is high exactly when `owed_o` ≥ 8.
- R8: `owed_o` never exceeds 9. An interval expiry at 9 with no handshake at the same edge keeps `owed_o` at 9 and sets `overflow_o`, which then stays high until reset.
- R9: When an interval expiry and a handshake fall on the same edge, `owed_o` is unchanged and `overflow_o` is not set, even when `owed_o` is 9.
- R10: `req_ready_i` high while `req_valid_o` is low has no effect: `owed_o` stays 0 until the next interval expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | High selects the shortened (high-temperature) interval |
| req_ready_i | input | 1 | Arbiter accepts one refresh at this edge if a request is valid |
| req_valid_o | output | 1 | At least one refresh is owed |
| req_urgent_o | output | 1 | Postponement limit reached (eight or more owed) |
| owed_o | output | OW (4 by default) | Number of refreshes currently owed, 0 to 9 |
| overflow_o | output | 1 | Sticky: an expiry arrived while nine were already owed |

## Verification
An interval expiry and an accepted request can fall on the same clock edge. In that case the owed count must come out unchanged instead of moving up and then down. At the ceiling of nine the coincidence must not be mistaken for an overflow. The bench provokes this by raising `req_ready_i` at the falling edge just before a known expiry edge. It does so once at a count of one and once at the ceiling. It then judges the count and the overflow flag at that edge and at the next. A lone expiry at the ceiling, twenty cycles later, must then set the flag, which shows the two cases are told apart.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Rounded-up integer division used to turn a time into a cycle count.
  function automatic longint unsigned ceil_div(input longint unsigned num,
                                               input longint unsigned den);
    return (num + den - 1) / den;
  endfunction

  // Action applied to the owed counter in one cycle.
  typedef enum logic [1:0] {
    OWED_HOLD = 2'd0,
    OWED_INC  = 2'd1,
    OWED_DEC  = 2'd2,
    OWED_OVF  = 2'd3
  } owed_op_e;

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int NORM_CYC = 3125,
  parameter int HOT_CYC  = 1563,
  parameter int CW       = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  output logic tick_o
);

  logic [CW-1:0] elapsed_q;
  logic [CW-1:0] limit;

  // The limit is picked every cycle, so a switch to the short interval
  // takes effect at once instead of waiting out a long interval.
  always_comb begin
    if (hot_i) limit = CW'(HOT_CYC - 1);
    else       limit = CW'(NORM_CYC - 1);
  end

  assign tick_o = (elapsed_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)      elapsed_q <= '0;
    else if (tick_o) elapsed_q <= '0;
    else             elapsed_q <= elapsed_q + 1'b1;
  end

endmodule

// File: rtl/rfsh_debt_counter.sv
module rfsh_debt_counter
  import rfsh_pkg::*;
#(
  parameter int MAX_OWED = 9,
  parameter int OW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          take_i,
  output logic [OW-1:0] owed_o,
  output logic          ovf_o
);

  localparam logic [OW-1:0] CEIL = OW'(MAX_OWED);

  owed_op_e      op;
  logic [OW-1:0] owed_q;
  logic          ovf_q;

  // A coincident expiry and acceptance cancel: one owed, one retired.
  always_comb begin
    op = OWED_HOLD;
    if (tick_i && !take_i) begin
      if (owed_q == CEIL) op = OWED_OVF;
      else                op = OWED_INC;
    end else if (take_i && !tick_i) begin
      op = OWED_DEC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      case (op)
        OWED_INC:  owed_q <= owed_q + 1'b1;
        OWED_DEC:  owed_q <= owed_q - 1'b1;
        OWED_OVF:  ovf_q  <= 1'b1;
        default:   owed_q <= owed_q;
      endcase
    end
  end

  assign owed_o = owed_q;
  assign ovf_o  = ovf_q;

endmodule

// File: rtl/rfsh_levels.sv
module rfsh_levels #(
  parameter int URGENT_AT = 8,
  parameter int OW        = 4
) (
  input  logic [OW-1:0] owed_i,
  output logic          valid_o,
  output logic          urgent_o
);

  assign valid_o  = (owed_i != '0);
  assign urgent_o = (owed_i >= OW'(URGENT_AT));

endmodule

// File: rtl/rfsh_scheduler.sv
module rfsh_scheduler
  import rfsh_pkg::*;
#(
  parameter int TCK_PS   = 2500,
  parameter int TREFI_PS = 7812500,
  parameter int MAX_OWED = 9,
  localparam int OW      = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hot_i,
  input  logic          req_ready_i,
  output logic          req_valid_o,
  output logic          req_urgent_o,
  output logic [OW-1:0] owed_o,
  output logic          overflow_o
);

  localparam int NORM_CYC  = int'(ceil_div(longint'(TREFI_PS), longint'(TCK_PS)));
  localparam int HOT_CYC   = int'(ceil_div(longint'(TREFI_PS), 2 * longint'(TCK_PS)));
  localparam int CW        = $clog2(NORM_CYC + 1);
  localparam int URGENT_AT = MAX_OWED - 1;

  logic          tick_w;
  logic          take_w;
  logic [OW-1:0] owed_w;
  logic          valid_w;

  rfsh_interval_timer #(
    .NORM_CYC(NORM_CYC),
    .HOT_CYC (HOT_CYC),
    .CW      (CW)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .hot_i (hot_i),
    .tick_o(tick_w)
  );

  assign take_w = valid_w && req_ready_i;

  rfsh_debt_counter #(
    .MAX_OWED(MAX_OWED),
    .OW      (OW)
  ) u_debt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_i(tick_w),
    .take_i(take_w),
    .owed_o(owed_w),
    .ovf_o (overflow_o)
  );

  rfsh_levels #(
    .URGENT_AT(URGENT_AT),
    .OW       (OW)
  ) u_levels (
    .owed_i  (owed_w),
    .valid_o (valid_w),
    .urgent_o(req_urgent_o)
  );

  assign req_valid_o = valid_w;
  assign owed_o      = owed_w;

endmodule

// File: rtl/rfsh_scheduler_chk.sv
module rfsh_scheduler_chk #(
  parameter int MAX_OWED = 9,
  parameter int OW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          req_ready_i,
  input logic          req_valid_o,
  input logic          req_urgent_o,
  input logic [OW-1:0] owed_o,
  input logic          overflow_o
);

  logic hs;
  assign hs = req_valid_o && req_ready_i;

  // R8
  ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed_o <= OW'(MAX_OWED));

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  // R8
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hs && owed_o == OW'(MAX_OWED)) |=> overflow_o);

  // R6
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> req_valid_o);

  // R5
  take_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !tick) |=> owed_o == OW'($past(owed_o) - 1'b1));

  // R2
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hs && owed_o < OW'(MAX_OWED)) |=> owed_o == OW'($past(owed_o) + 1'b1));

  // R9
  both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hs) |=> ($stable(owed_o) && overflow_o == $past(overflow_o)));

  // R10
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid_o && !tick) |=> owed_o == '0);

  // R7
  urgent_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_urgent_o |-> req_valid_o);

endmodule

bind rfsh_scheduler rfsh_scheduler_chk #(
  .MAX_OWED(MAX_OWED),
  .OW      (OW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick_w),
  .req_ready_i (req_ready_i),
  .req_valid_o (req_valid_o),
  .req_urgent_o(req_urgent_o),
  .owed_o      (owed_o),
  .overflow_o  (overflow_o)
);

// File: tb/sim_rfsh_scheduler.sv
`timescale 1ns/1ps
module sim_rfsh_scheduler;

  localparam int TCK = 1000;
  localparam int TRF = 19500;
  localparam int NORM = (TRF + TCK - 1) / TCK;            // 20
  localparam int HOT  = (TRF + 2 * TCK - 1) / (2 * TCK);  // 10

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hot_i = 1'b0;
  logic       req_ready_i = 1'b0;
  logic       req_valid_o;
  logic       req_urgent_o;
  logic [3:0] owed_o;
  logic       overflow_o;

  int compared = 0;
  int mismatched = 0;
  int ecount = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  rfsh_scheduler #(.TCK_PS(TCK), .TREFI_PS(TRF), .MAX_OWED(9)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .hot_i       (hot_i),
    .req_ready_i (req_ready_i),
    .req_valid_o (req_valid_o),
    .req_urgent_o(req_urgent_o),
    .owed_o      (owed_o),
    .overflow_o  (overflow_o)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, ecount, act, exp);
    end
  endtask

  task automatic wait_edge(input int n);
    while (ecount < n) @(negedge clk);
  endtask

  task automatic do_reset(input logic hot);
    @(negedge clk);
    rst_n = 1'b0;
    hot_i = hot;
    req_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 owed", int'(owed_o), 0);
    check("R1 valid", int'(req_valid_o), 0);
    check("R1 urgent", int'(req_urgent_o), 0);
    check("R1 overflow", int'(overflow_o), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    // Normal interval sweep under back-pressure: R2, R6, R7, R8
    do_reset(1'b0);
    for (int k = 1; k <= 10; k++) begin
      int before_v;
      int after_v;
      before_v = (k - 1 > 9) ? 9 : k - 1;
      after_v  = (k > 9) ? 9 : k;
      wait_edge(NORM * k - 1);
      check("R2 owed before expiry", int'(owed_o), before_v);
      check("R6 valid held", int'(req_valid_o), int'(before_v != 0));
      wait_edge(NORM * k);
      check("R2 owed after expiry", int'(owed_o), after_v);
      check("R5 valid level", int'(req_valid_o), int'(after_v != 0));
      check("R7 urgent level", int'(req_urgent_o), int'(after_v >= 8));
      check("R8 overflow", int'(overflow_o), int'(k >= 10));
    end
    // Drain one per edge: R5, then idle ready: R10
    req_ready_i = 1'b1;
    for (int j = 1; j <= 19; j++) begin
      wait_edge(NORM * 10 + j);
      if (j <= 9) check("R5 drain", int'(owed_o), 9 - j);
      else        check("R10 idle ready", int'(owed_o), 0);
    end
    wait_edge(NORM * 11);
    check("R10 expiry after idle", int'(owed_o), 1);
    wait_edge(NORM * 11 + 1);
    check("R5 accept", int'(owed_o), 0);
    check("R8 sticky", int'(overflow_o), 1);

    // Coincident expiry and acceptance at the ceiling: R9, then lone: R8
    do_reset(1'b0);
    wait_edge(NORM * 10 - 1);
    check("R9 pre owed", int'(owed_o), 9);
    req_ready_i = 1'b1;
    wait_edge(NORM * 10);
    check("R9 owed at ceiling", int'(owed_o), 9);
    check("R9 no overflow", int'(overflow_o), 0);
    req_ready_i = 1'b0;
    wait_edge(NORM * 10 + 1);
    check("R9 owed after", int'(owed_o), 9);
    wait_edge(NORM * 11);
    check("R8 lone expiry overflow", int'(overflow_o), 1);
    check("R8 saturated", int'(owed_o), 9);

    // Coincidence at a low count: R9
    do_reset(1'b0);
    wait_edge(NORM * 2 - 1);
    check("R6 owed kept", int'(owed_o), 1);
    req_ready_i = 1'b1;
    wait_edge(NORM * 2);
    check("R9 owed at one", int'(owed_o), 1);
    req_ready_i = 1'b0;
    wait_edge(NORM * 2 + 1);
    check("R9 owed after one", int'(owed_o), 1);

    // Hot interval sweep: R3
    do_reset(1'b1);
    for (int k = 1; k <= 9; k++) begin
      wait_edge(HOT * k - 1);
      check("R3 owed before expiry", int'(owed_o), k - 1);
      wait_edge(HOT * k);
      check("R3 owed after expiry", int'(owed_o), k);
    end

    // Switch to hot mid-interval: R4
    do_reset(1'b0);
    wait_edge(15);
    check("R4 before switch", int'(owed_o), 0);
    hot_i = 1'b1;
    wait_edge(16);
    check("R4 cut interval", int'(owed_o), 1);
    wait_edge(16 + HOT - 1);
    check("R4 hot interval pending", int'(owed_o), 1);
    wait_edge(16 + HOT);
    check("R4 hot interval done", int'(owed_o), 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #4000000;
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule